// File: doc/BRIEF.md
# Byte-Swapping IDE Register Window

This block sits between a big-endian host bus and the register set of an ATA device. The host sees a 4 KB window in which every register occupies its own 16-byte slot. Each host access carries a read or write strobe, an address, a size (byte, halfword or word) and write data. The block turns each access into at most one strobe on a simple register port toward the device. That port carries a register code, an access width, write data and read data.

Byte accesses reach the seven command-block registers and the control/alternate-status register. The control/alternate-status register answers at two different slots. Halfword and word accesses reach only the data register. Their bytes are reversed in both directions, so the little-endian device data appears in host byte order. Any access the window does not map produces no port strobe. A read of an unmapped location returns all ones, sized to the access. Read data is registered and returns one cycle after the read strobe, together with a one-cycle valid pulse.

Top module: `ide_regwin_bridge`

## Requirements
- R1: The register index is host address bits 11:4. Address bits above bit 11 and below bit 4 do not change the decode.
- R2: A byte access at index 1 to 7 strobes the port with register code equal to the index and width code 0. Write data is the low byte of the host write data, zero-extended. A read returns the port's low byte, zero-extended.
- R3: A byte access at index 8 or index 22 strobes the port with register code 8. A write reaches the device control register; a read returns the alternate status byte.
- R4: A byte access at any other index, index 0 included, produces no port strobe. A read of such a location returns 0x000000FF.
- R5: A halfword access (size code 1) at index 0 strobes register code 0 with width code 1. Write data is {16'h0, wdata[7:0], wdata[15:8]}. A read returns {16'h0, rdata[7:0], rdata[15:8]}.
- R6: A word access (size code 2) at index 0 strobes register code 0 with width code 2, as a single transfer. All four bytes are reversed on both write and read.
- R7: A halfword or word access at a non-zero index produces no port strobe. A read returns 0x0000FFFF for a halfword and 0xFFFFFFFF for a word.
- R8: Read data and a one-cycle valid pulse appear on the clock edge after the read strobe. The valid pulse stays low in cycles that follow no read, and the read data holds its last value.
- R9: Size code 3 is reserved. It produces no port strobe, and a read with it returns 0xFFFFFFFF.
- R10: When read and write strobes arrive together, only the write is carried out. No port read strobe and no valid pulse result.
- R11: After reset, the valid pulse is low and the read data register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | ADDR_W | Host byte address |
| h_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| h_wdata | input | 32 | Host write data, big-endian lane order |
| h_rdata | output | 32 | Registered read data |
| h_rvalid | output | 1 | One-cycle pulse marking h_rdata valid |
| p_rd | output | 1 | Port read strobe |
| p_wr | output | 1 | Port write strobe |
| p_reg | output | 4 | Port register code: 0 data, 1-7 command block, 8 control/alternate status |
| p_size | output | 2 | Port transfer width, same encoding as h_size |
| p_wdata | output | 32 | Port write data, device byte order |
| p_rdata | input | 32 | Port read data, valid during p_rd |

## Verification
The bench builds the block with its default parameters: a 32-bit host address, a 12-bit window and a 4-bit stride, which gives an 8-bit index. This reaches the high alias at index 22, the top index 255, and addresses whose bits above the window and below the stride are set. It can therefore check that those bits never disturb the decode. Every size code is applied at mapped and unmapped indices, with device data that changes on each access, so that a lane swap or a stale read value shows up.

// File: rtl/ide_regwin_pkg.sv
package ide_regwin_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [3:0] REG_DATA = 4'd0;
    localparam logic [3:0] REG_CTRL = 4'd8;

    typedef struct packed {
        logic [31:0] rdata;
        logic        rvalid;
    } rd_state_t;

endpackage

// File: rtl/ide_regwin_decode.sv
module ide_regwin_decode
    import ide_regwin_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int TF_LAST   = 7,
    parameter int ALIAS_LO  = 8,
    parameter int ALIAS_HI  = 22
) (
    input  logic [IDX_W-1:0] idx,
    input  acc_size_e        size,
    output logic             hit,
    output logic [3:0]       reg_code
);
    localparam logic [IDX_W-1:0] ALIAS_LO_L = IDX_W'(ALIAS_LO);
    localparam logic [IDX_W-1:0] ALIAS_HI_L = IDX_W'(ALIAS_HI);
    localparam logic [IDX_W-1:0] TF_LAST_L  = IDX_W'(TF_LAST);

    always_comb begin
        hit      = 1'b0;
        reg_code = REG_DATA;
        unique case (size)
            SZ_BYTE: begin
                if (idx != '0 && idx <= TF_LAST_L) begin
                    hit      = 1'b1;
                    reg_code = idx[3:0];
                end else if (idx == ALIAS_LO_L || idx == ALIAS_HI_L) begin
                    hit      = 1'b1;
                    reg_code = REG_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == '0) begin
                    hit      = 1'b1;
                    reg_code = REG_DATA;
                end
            end
            default: begin
                hit      = 1'b0;
                reg_code = REG_DATA;
            end
        endcase
    end

    // R4: byte hits never carry the data register code
    always_comb begin
        if (hit && size == SZ_BYTE)
            assert_byte_not_data_R4: assert (reg_code != REG_DATA);
    end

endmodule

// File: rtl/ide_regwin_swap.sv
module ide_regwin_swap #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign dout[8*g +: 8] = din[8*(BYTES-1-g) +: 8];
    end
endmodule

// File: rtl/ide_regwin_bridge.sv
module ide_regwin_bridge
    import ide_regwin_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int ALIAS_LO    = 8,
    parameter int ALIAS_HI    = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [1:0]        h_size,
    input  logic [31:0]       h_wdata,
    output logic [31:0]       h_rdata,
    output logic              h_rvalid,
    output logic              p_rd,
    output logic              p_wr,
    output logic [3:0]        p_reg,
    output logic [1:0]        p_size,
    output logic [31:0]       p_wdata,
    input  logic [31:0]       p_rdata
);
    localparam int IDX_W = WIN_BITS - STRIDE_BITS;

    logic [IDX_W-1:0] idx;
    acc_size_e        size;
    logic             hit;
    logic [3:0]       reg_code;
    logic [15:0]      wr_sw16, rd_sw16;
    logic [31:0]      wr_sw32, rd_sw32;
    logic [31:0]      rd_result;
    logic             rd_only;
    rd_state_t        st_d, st_q;
    logic             unused_addr_bits;

    assign idx  = h_addr[WIN_BITS-1:STRIDE_BITS];
    assign size = acc_size_e'(h_size);
    assign unused_addr_bits = ^{h_addr[ADDR_W-1:WIN_BITS], h_addr[STRIDE_BITS-1:0]};

    ide_regwin_decode #(
        .IDX_W   (IDX_W),
        .TF_LAST (7),
        .ALIAS_LO(ALIAS_LO),
        .ALIAS_HI(ALIAS_HI)
    ) u_decode (
        .idx     (idx),
        .size    (size),
        .hit     (hit),
        .reg_code(reg_code)
    );

    ide_regwin_swap #(.BYTES(2)) u_wsw16 (.din(h_wdata[15:0]), .dout(wr_sw16));
    ide_regwin_swap #(.BYTES(4)) u_wsw32 (.din(h_wdata),       .dout(wr_sw32));
    ide_regwin_swap #(.BYTES(2)) u_rsw16 (.din(p_rdata[15:0]), .dout(rd_sw16));
    ide_regwin_swap #(.BYTES(4)) u_rsw32 (.din(p_rdata),       .dout(rd_sw32));

    assign rd_only = h_rd && !h_wr;

    // port side
    always_comb begin
        p_rd    = rd_only && hit;
        p_wr    = h_wr && hit;
        p_reg   = reg_code;
        p_size  = h_size;
        unique case (size)
            SZ_BYTE: p_wdata = {24'h0, h_wdata[7:0]};
            SZ_HALF: p_wdata = {16'h0, wr_sw16};
            default: p_wdata = wr_sw32;
        endcase
    end

    // read result and next state
    always_comb begin
        unique case (size)
            SZ_BYTE: rd_result = hit ? {24'h0, p_rdata[7:0]} : 32'h0000_00FF;
            SZ_HALF: rd_result = hit ? {16'h0, rd_sw16}      : 32'h0000_FFFF;
            SZ_WORD: rd_result = hit ? rd_sw32               : 32'hFFFF_FFFF;
            default: rd_result = 32'hFFFF_FFFF;
        endcase
        st_d        = st_q;
        st_d.rvalid = rd_only;
        if (rd_only)
            st_d.rdata = rd_result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign h_rdata  = st_q.rdata;
    assign h_rvalid = st_q.rvalid;

    assert_excl_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(p_rd && p_wr));

    assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !h_wr) |=> h_rvalid);

    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_rd && !h_wr) |=> !h_rvalid);

    assert_rsvd_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_size == 2'd3) |-> !(p_rd || p_wr));

    assert_rsvd_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && !h_wr && h_size == 2'd3) |=> (h_rdata == 32'hFFFF_FFFF));

    assert_wide_at_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_rd || p_wr) && h_size != 2'd0) |-> (p_reg == REG_DATA));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_rd || h_wr) |=> $stable(h_rdata));

endmodule

// File: tb/tb_ide_regwin_bridge.sv
`timescale 1ns/1ps
module tb_ide_regwin_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_rd = 1'b0, h_wr = 1'b0;
    logic [31:0] h_addr = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic [31:0] h_rdata;
    logic        h_rvalid;
    logic        p_rd, p_wr;
    logic [3:0]  p_reg;
    logic [1:0]  p_size;
    logic [31:0] p_wdata;
    logic [31:0] p_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] exp_rdata = '0;
    logic        exp_rvalid = 1'b0;
    string       exp_tag = "R11";

    always #2.5 clk = ~clk;

    ide_regwin_bridge dut (
        .clk(clk), .rst_n(rst_n), .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr),
        .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_rvalid(h_rvalid),
        .p_rd(p_rd), .p_wr(p_wr), .p_reg(p_reg), .p_size(p_size),
        .p_wdata(p_wdata), .p_rdata(p_rdata)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] v, input int nbytes);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes; k++)
            r[8*k +: 8] = v[8*(nbytes-1-k) +: 8];
        return r;
    endfunction

    task automatic step(input logic rd, input logic wr, input logic [31:0] addr,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic [31:0] dev);
        int          idx;
        logic        mapped;
        logic [3:0]  code;
        logic [31:0] ewd, erd;
        string       tag;
        @(negedge clk);
        h_rd = rd; h_wr = wr; h_addr = addr; h_size = sz; h_wdata = wd; p_rdata = dev;
        idx = int'((addr & 32'hFFF) >> 4);
        mapped = 1'b0; code = 4'd0; ewd = '0; erd = 32'hFFFF_FFFF; tag = "R9";
        if (sz == 2'd0) begin
            ewd = {24'h0, wd[7:0]};
            if (idx >= 1 && idx <= 7) begin
                mapped = 1; code = 4'(idx); erd = {24'h0, dev[7:0]}; tag = "R2";
            end else if (idx == 8 || idx == 22) begin
                mapped = 1; code = 4'd8; erd = {24'h0, dev[7:0]}; tag = "R3";
            end else begin
                erd = 32'hFF; tag = "R4";
            end
        end else if (sz == 2'd1) begin
            ewd = rev({16'h0, wd[15:0]}, 2);
            if (idx == 0) begin
                mapped = 1; erd = rev({16'h0, dev[15:0]}, 2); tag = "R5";
            end else begin
                erd = 32'hFFFF; tag = "R7";
            end
        end else if (sz == 2'd2) begin
            ewd = rev(wd, 4);
            if (idx == 0) begin
                mapped = 1; erd = rev(dev, 4); tag = "R6";
            end else begin
                tag = "R7";
            end
        end
        if (rd && wr) tag = {tag, "/R10"};
        #1;
        check(tag, "p_rd", 32'(p_rd), 32'(rd && !wr && mapped));
        check(tag, "p_wr", 32'(p_wr), 32'(wr && mapped));
        if (p_rd || p_wr) begin
            check(tag, "p_reg (R1)", 32'(p_reg), 32'(code));
            check(tag, "p_size", 32'(p_size), 32'(sz));
        end
        if (wr && mapped)
            check(tag, "p_wdata", p_wdata, ewd);
        exp_rvalid = rd && !wr;
        if (exp_rvalid) exp_rdata = erd;
        exp_tag = {tag, "/R8"};
        @(posedge clk); #1;
        check(exp_tag, "h_rvalid", 32'(h_rvalid), 32'(exp_rvalid));
        check(exp_tag, "h_rdata", h_rdata, exp_rdata);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R11", "reset h_rvalid", 32'(h_rvalid), 32'h0);
        check("R11", "reset h_rdata", h_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R4: byte reads and writes across indices
        for (int i = 0; i < 24; i++) begin
            step(1, 0, 32'(i << 4), 2'd0, 32'h0, 32'hC0DE_0000 | 32'(i * 37 + 5));
            step(0, 1, 32'(i << 4), 2'd0, 32'hAB00_0000 | 32'(i * 11 + 3), 32'h0);
        end
        step(1, 0, 32'hFF0, 2'd0, 32'h0, 32'h1234_5678);
        // R1: high and low address bits ignored
        step(1, 0, 32'hDEAD_B03C, 2'd0, 32'h0, 32'h0000_0042);
        step(0, 1, 32'h7777_7165, 2'd0, 32'hFFFF_FF5A, 32'h0);
        step(1, 0, 32'h0001_0080, 2'd0, 32'h0, 32'h0000_0099);
        step(0, 1, 32'hABCD_E16F, 2'd0, 32'h0000_0011, 32'h0);
        // R5 R6: data register with swapping
        step(0, 1, 32'h0, 2'd1, 32'hFFFF_A1B2, 32'h0);
        step(1, 0, 32'h0, 2'd1, 32'h0, 32'hEEEE_3344);
        step(0, 1, 32'h0, 2'd2, 32'h0102_0304, 32'h0);
        step(1, 0, 32'h0, 2'd2, 32'h0, 32'hA0B0_C0D0);
        step(1, 0, 32'h5000_000C, 2'd2, 32'h0, 32'h1122_3344);
        // R7: wide accesses away from index 0
        step(1, 0, 32'h10, 2'd1, 32'h0, 32'h1111_2222);
        step(0, 1, 32'h80, 2'd1, 32'hBEEF, 32'h0);
        step(1, 0, 32'h160, 2'd2, 32'h0, 32'h3333_4444);
        step(0, 1, 32'h70, 2'd2, 32'hCAFE_F00D, 32'h0);
        // R9: reserved size
        step(1, 0, 32'h0, 2'd3, 32'h0, 32'h5555_6666);
        step(0, 1, 32'h10, 2'd3, 32'h77, 32'h0);
        // R10: simultaneous strobes
        step(1, 1, 32'h20, 2'd0, 32'h0000_0066, 32'h0000_0012);
        step(1, 1, 32'h0, 2'd2, 32'h8899_AABB, 32'h0);
        // R8: idle cycles hold data, back-to-back reads
        step(0, 0, 32'h0, 2'd0, 32'h0, 32'h0);
        step(1, 0, 32'h30, 2'd0, 32'h0, 32'h0000_00A5);
        step(1, 0, 32'h40, 2'd0, 32'h0, 32'h0000_005A);
        step(0, 0, 32'h40, 2'd0, 32'h0, 32'h0000_0000);
        step(0, 0, 32'h0, 2'd2, 32'h0, 32'hFFFF_0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule